// File: doc/BRIEF.md
# Multi-Mode Event Counter

This block is a counter whose count source is chosen by a three-bit mode field. The counter can advance on every clock. It can also follow two external inputs as a quadrature decoder, using rising edges of one input, of the other input, or of both. Three further modes use the first external input as a control line: one restarts the count, one gates counting, and one starts counting. Counting is always qualified by an enable bit. When the count passes its bounds it wraps, and a one-cycle event pulse marks each wrap.

Software reaches the block through a flat write/read register port. The port holds four registers: control, mode, count and reload limit.

Control register layout:
- bit 0: enable
- bit 1: direction (0 up, 1 down)
- bit 2: deferred-reload enable

Register offsets: control 0x0, mode 0x4, count 0x8, reload limit 0xC.

Mode codes:

| Code | Mode |
|------|------|
| 0 | free count on every clock |
| 1 | quadrature, stepping on rising edges of input B |
| 2 | quadrature, stepping on rising edges of input A |
| 3 | quadrature, stepping on rising edges of both inputs |
| 4 | restart |
| 5 | gated |
| 6 | start on edge |
| 7 | idle |

Both external inputs pass through a two-flop synchronizer before any level or edge is used.

Top module: `mscnt_top`

## Requirements
- R1: After reset, control, mode and count read 0. The reload limit reads all ones. The event and direction outputs are low.
- R2: In mode 0 with enable set, the count steps once per clock. With enable clear, the count holds in every mode.
- R3: Counting up, a step taken while the count is at or above the active limit loads 0 and pulses the event output high for one cycle.
- R4: Counting down, a step taken at count 0 loads the reload limit and pulses the event output.
- R5: With deferred reload clear, a write to the limit takes effect at once. With it set, the new limit becomes active only at the next wrap or underflow. A read of the limit returns the last written value.
- R6: In mode 1, each rising edge of B steps the count: up when A is high, down when A is low.
- R7: In mode 2, each rising edge of A steps the count: up when B is low, down when B is high.
- R8: In mode 3, a rising edge of A steps as in R7 and a rising edge of B steps as in R6. Rising edges on both inputs in the same cycle cause no step.
- R9: In modes 1 to 3, the direction bit and the direction output follow the decoded direction of the last step. Software writes to the direction bit are ignored.
- R10: In mode 4, the count steps each clock. A rising edge of A loads 0 when counting up, or the active limit when counting down.
- R11: In mode 5, the count steps only while A is high, and it keeps its value when A goes low.
- R12: In mode 6, the count holds until a rising edge of A. After that edge it steps each clock, starting from its held value, until enable is cleared.
- R13: A software write to the count register replaces the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data for bus_addr (combinational) |
| pin_a | input | 1 | External input A (asynchronous) |
| pin_b | input | 1 | External input B (asynchronous) |
| evt_o | output | 1 | One-cycle wrap/underflow event |
| dir_o | output | 1 | Current count direction (1 = down) |

## Verification
A wrong direction or limit register shows up at the count register within one step. It appears as a count moving the wrong way or wrapping at the wrong value, and the event pulse lands in the wrong cycle. A stuck or mis-set start flag, gate decode or edge detector shows as a count that fails to move, or that moves while it should hold. This is visible a fixed three clocks after an external input changes. Quadrature sequences are checked by comparing the final count against the signed number of edges applied, so a single miscounted edge is exposed.

// File: rtl/mscnt_pkg.sv
`timescale 1ns/1ps
package mscnt_pkg;

    localparam int ADDR_W = 4;

    localparam logic [ADDR_W-1:0] OFS_CTL = 4'h0;
    localparam logic [ADDR_W-1:0] OFS_MOD = 4'h4;
    localparam logic [ADDR_W-1:0] OFS_CNT = 4'h8;
    localparam logic [ADDR_W-1:0] OFS_LIM = 4'hC;

    localparam int CTL_EN  = 0;
    localparam int CTL_DIR = 1;
    localparam int CTL_PRE = 2;

    typedef enum logic [2:0] {
        MD_FREE    = 3'd0,
        MD_QUAD_B  = 3'd1,
        MD_QUAD_A  = 3'd2,
        MD_QUAD_AB = 3'd3,
        MD_RESTART = 3'd4,
        MD_GATE    = 3'd5,
        MD_START   = 3'd6,
        MD_IDLE    = 3'd7
    } mode_e;

    typedef struct packed {
        logic preload;
        logic dir;
        logic en;
    } ctl_t;

    typedef struct packed {
        logic lvl;
        logic rise;
    } pin_t;

    function automatic logic is_quad(mode_e m);
        return (m == MD_QUAD_B) || (m == MD_QUAD_A) || (m == MD_QUAD_AB);
    endfunction

endpackage

// File: rtl/mscnt_pin_sync.sv
`timescale 1ns/1ps
module mscnt_pin_sync
    import mscnt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output pin_t pin_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst) sr_q <= '0;
        else     sr_q <= {sr_q[DEPTH-2:0], pin_i};
    end

    always_comb begin
        pin_o.lvl  = sr_q[STAGES-1];
        pin_o.rise = sr_q[STAGES-1] & ~sr_q[STAGES];
    end

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        pin_o.rise |=> !pin_o.rise); // R8
endmodule

// File: rtl/mscnt_regs.sv
`timescale 1ns/1ps
module mscnt_regs
    import mscnt_pkg::*;
#(
    parameter int          W          = 16,
    parameter logic [W-1:0] RST_LIMIT = {W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      cnt_i,
    input  logic              wrap_i,
    input  logic              hw_dir_vld_i,
    input  logic              hw_dir_i,
    output ctl_t              ctl_o,
    output mode_e             mode_o,
    output logic [W-1:0]      lim_act_o,
    output logic [W-1:0]      lim_shd_o,
    output logic              cnt_we_o,
    output logic [W-1:0]      cnt_wdata_o
);
    ctl_t         ctl_q;
    mode_e        mode_q;
    logic [W-1:0] act_q, shd_q;
    logic         we_ctl, we_mod, we_lim;

    assign we_ctl = bus_we && (bus_addr == OFS_CTL);
    assign we_mod = bus_we && (bus_addr == OFS_MOD);
    assign we_lim = bus_we && (bus_addr == OFS_LIM);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            mode_q <= MD_FREE;
            act_q  <= RST_LIMIT;
            shd_q  <= RST_LIMIT;
        end else begin
            if (we_ctl) begin
                ctl_q.en      <= bus_wdata[CTL_EN];
                ctl_q.preload <= bus_wdata[CTL_PRE];
            end
            if (hw_dir_vld_i)
                ctl_q.dir <= hw_dir_i;
            else if (we_ctl && !is_quad(mode_q))
                ctl_q.dir <= bus_wdata[CTL_DIR];
            if (we_mod)
                mode_q <= mode_e'(bus_wdata[2:0]);
            if (we_lim)
                shd_q <= bus_wdata;
            if (we_lim && !ctl_q.preload)
                act_q <= bus_wdata;
            else if (ctl_q.preload && wrap_i)
                act_q <= shd_q;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_CTL: begin
                bus_rdata[CTL_EN]  = ctl_q.en;
                bus_rdata[CTL_DIR] = ctl_q.dir;
                bus_rdata[CTL_PRE] = ctl_q.preload;
            end
            OFS_MOD: bus_rdata[2:0] = mode_q;
            OFS_CNT: bus_rdata = cnt_i;
            OFS_LIM: bus_rdata = shd_q;
            default: bus_rdata = '0;
        endcase
    end

    assign ctl_o       = ctl_q;
    assign mode_o      = mode_q;
    assign lim_act_o   = act_q;
    assign lim_shd_o   = shd_q;
    assign cnt_we_o    = bus_we && (bus_addr == OFS_CNT);
    assign cnt_wdata_o = bus_wdata;

    AST_PRELOAD_DEFER: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.preload && !wrap_i) |=> $stable(act_q)); // R5
    AST_QUAD_DIR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (is_quad(mode_q) && !hw_dir_vld_i) |=> $stable(ctl_q.dir)); // R9
endmodule

// File: rtl/mscnt_engine.sv
`timescale 1ns/1ps
module mscnt_engine
    import mscnt_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl_i,
    input  mode_e        mode_i,
    input  pin_t         pa_i,
    input  pin_t         pb_i,
    input  logic [W-1:0] lim_act_i,
    input  logic [W-1:0] lim_shd_i,
    input  logic         cnt_we_i,
    input  logic [W-1:0] cnt_wdata_i,
    output logic [W-1:0] cnt_o,
    output logic         evt_o,
    output logic         wrap_o,
    output logic         hw_dir_vld_o,
    output logic         hw_dir_o
);
    logic [W-1:0] cnt_q;
    logic         evt_q, started_q;
    logic         step, step_dn, restart;

    always_comb begin
        step         = 1'b0;
        restart      = 1'b0;
        step_dn      = ctl_i.dir;
        hw_dir_vld_o = 1'b0;
        unique case (mode_i)
            MD_FREE: step = ctl_i.en;
            MD_QUAD_B: if (ctl_i.en && pb_i.rise) begin
                step = 1'b1;
                step_dn = ~pa_i.lvl;
                hw_dir_vld_o = 1'b1;
            end
            MD_QUAD_A: if (ctl_i.en && pa_i.rise) begin
                step = 1'b1;
                step_dn = pb_i.lvl;
                hw_dir_vld_o = 1'b1;
            end
            MD_QUAD_AB: if (ctl_i.en && (pa_i.rise ^ pb_i.rise)) begin
                step = 1'b1;
                step_dn = pa_i.rise ? pb_i.lvl : ~pa_i.lvl;
                hw_dir_vld_o = 1'b1;
            end
            MD_RESTART: if (ctl_i.en) begin
                restart = pa_i.rise;
                step = ~pa_i.rise;
            end
            MD_GATE:  step = ctl_i.en && pa_i.lvl;
            MD_START: step = ctl_i.en && started_q;
            default:  step = 1'b0;
        endcase
        hw_dir_o = step_dn;
        wrap_o   = step && !cnt_we_i &&
                   (step_dn ? (cnt_q == '0) : (cnt_q >= lim_act_i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q     <= '0;
            evt_q     <= 1'b0;
            started_q <= 1'b0;
        end else begin
            evt_q <= wrap_o;
            if (!ctl_i.en || mode_i != MD_START) started_q <= 1'b0;
            else if (pa_i.rise)                   started_q <= 1'b1;
            if (cnt_we_i)
                cnt_q <= cnt_wdata_i;
            else if (restart)
                cnt_q <= ctl_i.dir ? lim_act_i : '0;
            else if (step) begin
                if (step_dn) cnt_q <= wrap_o ? lim_shd_i : cnt_q - 1'b1;
                else         cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign evt_o = evt_q;

    AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl_i.en && !cnt_we_i) |=> $stable(cnt_q)); // R2
    AST_UP_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && !step_dn) |=> (evt_q && cnt_q == '0)); // R3
    AST_DN_WRAP_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (wrap_o && step_dn) |=> (evt_q && cnt_q == $past(lim_shd_i))); // R4
    AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mode_i == MD_GATE && !pa_i.lvl && !cnt_we_i) |=> $stable(cnt_q)); // R11
endmodule

// File: rtl/mscnt_top.sv
`timescale 1ns/1ps
module mscnt_top
    import mscnt_pkg::*;
#(
    parameter int W         = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic              pin_a,
    input  logic              pin_b,
    output logic              evt_o,
    output logic              dir_o
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pins_raw;
    pin_t [NPIN-1:0] pins;
    ctl_t            ctl;
    mode_e           mode;
    logic [W-1:0]    lim_act, lim_shd, cnt, cnt_wdata;
    logic            cnt_we, wrap, hw_dir_vld, hw_dir;

    assign pins_raw = {pin_b, pin_a};

    for (genvar g = 0; g < NPIN; g++) begin : g_sync
        mscnt_pin_sync #(.STAGES(SYNC_STGS)) u_sync (
            .clk(clk), .rst(rst), .pin_i(pins_raw[g]), .pin_o(pins[g])
        );
    end

    mscnt_regs #(.W(W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .cnt_i(cnt), .wrap_i(wrap),
        .hw_dir_vld_i(hw_dir_vld), .hw_dir_i(hw_dir),
        .ctl_o(ctl), .mode_o(mode),
        .lim_act_o(lim_act), .lim_shd_o(lim_shd),
        .cnt_we_o(cnt_we), .cnt_wdata_o(cnt_wdata)
    );

    mscnt_engine #(.W(W)) u_eng (
        .clk(clk), .rst(rst),
        .ctl_i(ctl), .mode_i(mode),
        .pa_i(pins[0]), .pb_i(pins[1]),
        .lim_act_i(lim_act), .lim_shd_i(lim_shd),
        .cnt_we_i(cnt_we), .cnt_wdata_i(cnt_wdata),
        .cnt_o(cnt), .evt_o(evt_o), .wrap_o(wrap),
        .hw_dir_vld_o(hw_dir_vld), .hw_dir_o(hw_dir)
    );

    assign dir_o = ctl.dir;
endmodule

// File: tb/mscnt_top_test.sv
`timescale 1ns/1ps
module mscnt_top_test;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         bus_we = 1'b0;
    logic [3:0]   bus_addr = 4'h0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         pin_a = 1'b0, pin_b = 1'b0;
    logic         evt_o, dir_o;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mscnt_top #(.W(W)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_a(pin_a), .pin_b(pin_b), .evt_o(evt_o), .dir_o(dir_o)
    );

    localparam logic [3:0] A_CTL = 4'h0, A_MOD = 4'h4, A_CNT = 4'h8, A_LIM = 4'hC;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input int d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = W'(d);
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output int v);
        bus_addr = a;
        #1;
        v = int'(bus_rdata);
    endtask

    task automatic setup(input int mode, input int lim, input int cnt);
        wr(A_CTL, 0); wr(A_MOD, mode); wr(A_LIM, lim); wr(A_CNT, cnt);
    endtask

    task automatic quad(input bit fwd, input int n);
        for (int i = 0; i < n; i++) begin
            if (fwd) begin
                pin_a = 1; tick(5); pin_b = 1; tick(5); pin_a = 0; tick(5); pin_b = 0; tick(5);
            end else begin
                pin_b = 1; tick(5); pin_a = 1; tick(5); pin_b = 0; tick(5); pin_a = 0; tick(5);
            end
        end
    endtask

    task automatic t_reset_state();
        int v;
        rd(A_CTL, v); chk("R1 ctl", v, 0);
        rd(A_MOD, v); chk("R1 mode", v, 0);
        rd(A_CNT, v); chk("R1 cnt", v, 0);
        rd(A_LIM, v); chk("R1 limit", v, 65535);
        chk("R1 evt", int'(evt_o), 0);
        chk("R1 dir", int'(dir_o), 0);
    endtask

    task automatic t_free_up();
        int v, evts = 0;
        setup(0, 3, 0);
        wr(A_CTL, 1);
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (evt_o) evts++;
        end
        rd(A_CNT, v); chk("R3 up wrap count", v, 0);
        chk("R3 event pulses", evts, 2);
        setup(0, 5, 9);
        wr(A_CTL, 1);
        tick(1);
        rd(A_CNT, v); chk("R3 above limit wraps", v, 0);
        chk("R3 event above limit", int'(evt_o), 1);
        tick(1);
        chk("R3 event single cycle", int'(evt_o), 0);
    endtask

    task automatic t_free_down();
        int v, evts = 0;
        setup(0, 3, 3);
        wr(A_CTL, 3);
        for (int i = 0; i < 8; i++) begin
            tick(1);
            if (evt_o) evts++;
        end
        rd(A_CNT, v); chk("R4 down count", v, 3);
        chk("R4 event pulses", evts, 2);
        chk("R4 dir output", int'(dir_o), 1);
    endtask

    task automatic t_enable();
        int v0, v1;
        setup(0, 1000, 100);
        wr(A_CTL, 1);
        rd(A_CNT, v0); tick(10); rd(A_CNT, v1);
        chk("R2 one step per clock", v1 - v0, 10);
        wr(A_CTL, 0);
        rd(A_CNT, v0); tick(10); rd(A_CNT, v1);
        chk("R2 disabled holds", v1, v0);
        wr(A_CNT, 1234);
        rd(A_CNT, v0); chk("R13 count write", v0, 1234);
    endtask

    task automatic t_preload();
        int v;
        wr(A_CTL, 0); wr(A_MOD, 0); wr(A_LIM, 3);
        wr(A_CTL, 4); wr(A_LIM, 10); wr(A_CNT, 0);
        wr(A_CTL, 5);
        tick(8);
        rd(A_CNT, v); chk("R5 deferred limit", v, 4);
        rd(A_LIM, v); chk("R5 limit readback", v, 10);
        setup(0, 3, 0);
        wr(A_LIM, 10);
        wr(A_CTL, 1);
        tick(8);
        rd(A_CNT, v); chk("R5 immediate limit", v, 8);
    endtask

    task automatic t_quad(input int mode, input int fwd_exp, input int rev_exp, input string req);
        int v;
        setup(mode, 100, 10);
        wr(A_CTL, 1);
        quad(1, 3);
        rd(A_CNT, v); chk({req, " forward"}, v, fwd_exp);
        chk("R9 dir up", int'(dir_o), 0);
        quad(0, 2);
        rd(A_CNT, v); chk({req, " reverse"}, v, rev_exp);
        chk("R9 dir down", int'(dir_o), 1);
    endtask

    task automatic t_quad_dir_ignore();
        int v;
        wr(A_CTL, 1);
        tick(2);
        rd(A_CTL, v); chk("R9 sw dir write ignored", (v >> 1) & 1, 1);
        chk("R9 dir output kept", int'(dir_o), 1);
    endtask

    task automatic t_quad_both();
        int v;
        pin_a = 1; pin_b = 1; tick(6);
        pin_a = 0; pin_b = 0; tick(6);
        rd(A_CNT, v); chk("R8 simultaneous edges no step", v, 12);
    endtask

    task automatic t_restart();
        int v;
        setup(4, 1000, 0);
        wr(A_CTL, 1);
        tick(50);
        rd(A_CNT, v); chk("R10 counting before edge", int'(v >= 40), 1);
        pin_a = 1; tick(3);
        rd(A_CNT, v); chk("R10 up restart to 0", v, 0);
        pin_a = 0; tick(5);
        wr(A_CTL, 3);
        tick(20);
        pin_a = 1; tick(3);
        rd(A_CNT, v); chk("R10 down restart to limit", v, 1000);
        pin_a = 0; tick(5);
    endtask

    task automatic t_gate();
        int v;
        setup(5, 1000, 0);
        wr(A_CTL, 1);
        tick(5);
        rd(A_CNT, v); chk("R11 low gate holds", v, 0);
        pin_a = 1; tick(7);
        pin_a = 0; tick(6);
        rd(A_CNT, v); chk("R11 counts while high", v, 7);
        tick(5);
        rd(A_CNT, v); chk("R11 keeps value", v, 7);
    endtask

    task automatic t_start();
        int v;
        setup(6, 1000, 5);
        wr(A_CTL, 1);
        tick(6);
        rd(A_CNT, v); chk("R12 waits for edge", v, 5);
        pin_a = 1; tick(3);
        pin_a = 0; tick(10);
        rd(A_CNT, v); chk("R12 counts from held value", v, 15);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tick(1);
        t_reset_state();
        t_enable();
        t_free_up();
        t_free_down();
        t_preload();
        t_quad(1, 13, 11, "R6");
        t_quad_dir_ignore();
        t_quad(2, 13, 11, "R7");
        t_quad(3, 16, 12, "R8");
        t_quad_both();
        t_restart();
        t_gate();
        t_start();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule